// File: doc/BRIEF.md
# Sixteen-pin GPIO bank with interrupt detection and low-power pin levels

This block is one bank of sixteen general-purpose pins behind a small synchronous register bus. Software sets each pin's direction and output level, and picks for each pin whether it raises an interrupt on an edge or on a level, and which polarity. Every detection is held in a status register that software clears by writing ones. The bank interrupt line is the OR of the pending status bits that are not masked.

Two system conditions replace the normal output levels. While the bank is in sleep mode, output pins drive a per-pin sleep level and a second per-pin mask also gates the interrupt. While the battery-fault input is high, output pins drive a per-pin fault level, and this takes priority over both sleep and normal levels. An autosleep option keeps the bank in sleep mode after the sleep request drops, until an interrupt wakes it. Four such banks are meant to sit 0x100 bytes apart in a larger map. Each register is 16 bits wide at a word-aligned byte offset, and bus address bits [1:0] are ignored.

Top module: `pio_bank16`

## Requirements
- R1: After reset every configuration register reads 0, except the interrupt mask, which reads 0xFFFF. pin_oe and irq are 0.
- R2: These registers can be written and read back at the given byte offsets: interrupt mask 0x00 (1 = masked), direction 0x04, output level 0x08, trigger kind 0x0C, edge polarity 0x10, level polarity 0x14, sleep mask 0x18, sleep level 0x1C, fault level 0x20, alternate-function flags 0x28 and sleep configuration 0x2C.
- R3: pin_oe equals the direction register (1 = output). On an output pin, pin_out is the selected level. On an input pin, pin_out is 0. In normal operation the selected level is the output-level register bit.
- R4: The pin-status register at 0x30 returns pin_in after a two-stage synchroniser. A change on pin_in can be read there two clock edges later.
- R5: Detection works on the synchronised pin. A trigger-kind bit of 1 selects edge detection, where an edge-polarity bit of 1 means rising and 0 means falling. A trigger-kind bit of 0 selects level detection, where a level-polarity bit of 1 means high and 0 means low. Each detection sets the pin's bit in the status register at 0x24.
- R6: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. A detection in the same cycle as the clear leaves the bit set.
- R7: The alternate-function register drives the alt_sel output bit for bit.
- R8: irq is 1 exactly when some status bit is 1 and its interrupt-mask bit is 0 (sleep mode off).
- R9: While the bank is in sleep mode, a sleep-mask bit of 1 also masks that pin's status bit from irq.
- R10: In sleep mode, output pins drive their sleep-level bit.
- R11: While batt_fault is high, output pins drive their fault-level bit, whether or not the bank is in sleep mode.
- R12: With sleep-configuration bit 1 at 0, sleep mode follows sleep_req after synchronisation. With it at 1, a rising sleep_req enters sleep mode, and the bank stays there after sleep_req falls, until irq is raised.
- R13: Reads of unmapped offsets return 0. Writes to the pin-status register and to unmapped offsets have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bank clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | Byte address within the bank |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| pin_in | input | 16 | Pad input levels |
| pin_out | output | 16 | Pad output levels |
| pin_oe | output | 16 | Pad output enables |
| alt_sel | output | 16 | Alternate-function flags for the pad mux |
| sleep_req | input | 1 | System sleep request, asynchronous |
| batt_fault | input | 1 | Battery-fault condition, asynchronous |
| irq | output | 1 | Bank interrupt |

## Verification
The bench aims at the cases where interrupt logic usually goes wrong. A falling edge on a pin set for rising edges must leave the status bit at 0; a detector that ignores the polarity bit would set it. A held high level must survive a write-one clear; a design that lets the clear win would read back 0. The sleep mask must hide a pending bit only while sleep mode is on, and the fault level must win over a sleep level that is applied at the same time. Autosleep is checked by letting sleep_req fall and confirming the sleep levels persist, then by raising an unmasked edge interrupt and confirming normal levels return. A design without the sticky mode would drop the sleep levels too early, and one without the wake path would never leave sleep mode.

// File: rtl/pio_pkg.sv
package pio_pkg;
  // Word indices (byte offset / 4) decoded by software drivers.
  localparam int unsigned OFS_MASK  = 0;
  localparam int unsigned OFS_DIR   = 1;
  localparam int unsigned OFS_OUT   = 2;
  localparam int unsigned OFS_TRIG  = 3;
  localparam int unsigned OFS_EDGE  = 4;
  localparam int unsigned OFS_LVL   = 5;
  localparam int unsigned OFS_SMASK = 6;
  localparam int unsigned OFS_SOUT  = 7;
  localparam int unsigned OFS_BFOUT = 8;
  localparam int unsigned OFS_STAT  = 9;
  localparam int unsigned OFS_ALT   = 10;
  localparam int unsigned OFS_SCONF = 11;
  localparam int unsigned OFS_PINS  = 12;
  localparam int unsigned NUM_CFG   = 12;
  localparam int unsigned AUTOSLEEP_BIT = 1;

  typedef enum logic [1:0] {
    DRV_NORMAL = 2'd0,
    DRV_SLEEP  = 2'd1,
    DRV_FAULT  = 2'd2
  } drv_src_e;
endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [W-1:0] stg_d;
      if (s == 0) begin : g_first
        assign stg_d = d;
      end else begin : g_next
        assign stg_d = stg_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= '0;
        else        stg_q[s] <= stg_d;
      end
    end
  endgenerate

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/pio_detect.sv
module pio_detect #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_s,
  input  logic [W-1:0] trig,
  input  logic [W-1:0] edge_sel,
  input  logic [W-1:0] lvl_sel,
  input  logic         clr_en,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] det,
  output logic [W-1:0] stat
);
  logic [W-1:0] prev_q, stat_q, stat_d;
  logic [W-1:0] rise, fall, edge_hit, lvl_hit, clr_bits;

  always_comb begin
    rise     = pin_s & ~prev_q;
    fall     = ~pin_s & prev_q;
    edge_hit = (edge_sel & rise) | (~edge_sel & fall);
    lvl_hit  = ~(pin_s ^ lvl_sel);
    det      = (trig & edge_hit) | (~trig & lvl_hit);
    clr_bits = clr_en ? clr_mask : '0;
    stat_d   = (stat_q & ~clr_bits) | det;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      stat_q <= '0;
    end else begin
      prev_q <= pin_s;
      stat_q <= stat_d;
    end
  end

  assign stat = stat_q;
endmodule

// File: rtl/pio_regs.sv
module pio_regs
  import pio_pkg::*;
#(
  parameter int W  = 16,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic [W-1:0]  stat,
  input  logic [W-1:0]  pin_s,
  output logic [W-1:0]  mask,
  output logic [W-1:0]  dir,
  output logic [W-1:0]  dout,
  output logic [W-1:0]  trig,
  output logic [W-1:0]  edge_sel,
  output logic [W-1:0]  lvl_sel,
  output logic [W-1:0]  smask,
  output logic [W-1:0]  sout,
  output logic [W-1:0]  bfout,
  output logic [W-1:0]  alt,
  output logic [W-1:0]  sconf,
  output logic          clr_en
);
  localparam int IW = AW - 2;

  logic [IW-1:0] widx;
  logic [W-1:0]  cfg_q [NUM_CFG];
  logic [W-1:0]  cfg_d [NUM_CFG];
  logic [1:0]    unused_lsb;

  assign widx       = bus_addr[AW-1:2];
  assign unused_lsb = bus_addr[1:0];

  generate
    for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg
      localparam logic [W-1:0] RST_VAL = (g == OFS_MASK) ? '1 : '0;
      logic wr_en;
      assign wr_en = bus_we && (widx == IW'(g)) && (g != OFS_STAT);
      always_comb cfg_d[g] = wr_en ? bus_wdata : cfg_q[g];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q[g] <= RST_VAL;
        else        cfg_q[g] <= cfg_d[g];
      end
    end
  endgenerate

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NUM_CFG; i++) begin
      if (widx == IW'(i)) bus_rdata = cfg_q[i];
    end
    if (widx == IW'(OFS_STAT)) bus_rdata = stat;
    if (widx == IW'(OFS_PINS)) bus_rdata = pin_s;
  end

  assign clr_en   = bus_we && (widx == IW'(OFS_STAT));
  assign mask     = cfg_q[OFS_MASK];
  assign dir      = cfg_q[OFS_DIR];
  assign dout     = cfg_q[OFS_OUT];
  assign trig     = cfg_q[OFS_TRIG];
  assign edge_sel = cfg_q[OFS_EDGE];
  assign lvl_sel  = cfg_q[OFS_LVL];
  assign smask    = cfg_q[OFS_SMASK];
  assign sout     = cfg_q[OFS_SOUT];
  assign bfout    = cfg_q[OFS_BFOUT];
  assign alt      = cfg_q[OFS_ALT];
  assign sconf    = cfg_q[OFS_SCONF];
endmodule

// File: rtl/pio_drive.sv
module pio_drive
  import pio_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sleep_s,
  input  logic         fault_s,
  input  logic         autosleep,
  input  logic         irq,
  input  logic [W-1:0] dir,
  input  logic [W-1:0] dout,
  input  logic [W-1:0] sout,
  input  logic [W-1:0] bfout,
  output logic         sleep_mode,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe
);
  logic     sleep_prev_q, mode_q, mode_d;
  drv_src_e src;
  logic [W-1:0] level;

  always_comb begin
    if (autosleep) mode_d = (mode_q | (sleep_s & ~sleep_prev_q)) & ~irq;
    else           mode_d = sleep_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sleep_prev_q <= 1'b0;
      mode_q       <= 1'b0;
    end else begin
      sleep_prev_q <= sleep_s;
      mode_q       <= mode_d;
    end
  end

  always_comb begin
    if (fault_s)     src = DRV_FAULT;
    else if (mode_q) src = DRV_SLEEP;
    else             src = DRV_NORMAL;
    case (src)
      DRV_FAULT: level = bfout;
      DRV_SLEEP: level = sout;
      default:   level = dout;
    endcase
  end

  assign sleep_mode = mode_q;
  assign pin_out    = level & dir;
  assign pin_oe     = dir;
endmodule

// File: rtl/pio_bank16.sv
module pio_bank16
  import pio_pkg::*;
#(
  parameter int PINS  = 16,
  parameter int AW    = 6,
  parameter int SYNC  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_we,
  input  logic [PINS-1:0] bus_wdata,
  output logic [PINS-1:0] bus_rdata,
  input  logic [PINS-1:0] pin_in,
  output logic [PINS-1:0] pin_out,
  output logic [PINS-1:0] pin_oe,
  output logic [PINS-1:0] alt_sel,
  input  logic            sleep_req,
  input  logic            batt_fault,
  output logic            irq
);
  logic [PINS-1:0] pin_s, stat_w, det_w;
  logic [PINS-1:0] mask_q, dir_q, dout_q, trig_q, edge_q, lvl_q;
  logic [PINS-1:0] smask_q, sout_q, bfout_q, sconf_q, eff_mask;
  logic [1:0]      ctl_s;
  logic            sleep_s, fault_s, clr_en, sleep_mode;
  logic            unused_sconf;

  pio_sync #(.W(PINS), .STAGES(SYNC)) u_pin_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_s)
  );

  pio_sync #(.W(2), .STAGES(SYNC)) u_ctl_sync (
    .clk(clk), .rst_n(rst_n), .d({batt_fault, sleep_req}), .q(ctl_s)
  );
  assign sleep_s = ctl_s[0];
  assign fault_s = ctl_s[1];

  pio_regs #(.W(PINS), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .stat(stat_w), .pin_s(pin_s),
    .mask(mask_q), .dir(dir_q), .dout(dout_q), .trig(trig_q),
    .edge_sel(edge_q), .lvl_sel(lvl_q), .smask(smask_q), .sout(sout_q),
    .bfout(bfout_q), .alt(alt_sel), .sconf(sconf_q), .clr_en(clr_en)
  );

  pio_detect #(.W(PINS)) u_det (
    .clk(clk), .rst_n(rst_n), .pin_s(pin_s), .trig(trig_q),
    .edge_sel(edge_q), .lvl_sel(lvl_q), .clr_en(clr_en),
    .clr_mask(bus_wdata), .det(det_w), .stat(stat_w)
  );

  always_comb begin
    eff_mask = mask_q | (sleep_mode ? smask_q : '0);
    irq      = |(stat_w & ~eff_mask);
  end

  pio_drive #(.W(PINS)) u_drv (
    .clk(clk), .rst_n(rst_n), .sleep_s(sleep_s), .fault_s(fault_s),
    .autosleep(sconf_q[AUTOSLEEP_BIT]), .irq(irq),
    .dir(dir_q), .dout(dout_q), .sout(sout_q), .bfout(bfout_q),
    .sleep_mode(sleep_mode), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  assign unused_sconf = ^sconf_q;
endmodule

// File: rtl/pio_bank16_chk.sv
module pio_bank16_chk
  import pio_pkg::*;
#(
  parameter int W  = 16,
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] bus_addr,
  input logic          bus_we,
  input logic [W-1:0]  bus_wdata,
  input logic [W-1:0]  pin_oe,
  input logic [W-1:0]  pin_out,
  input logic          irq,
  input logic [W-1:0]  stat,
  input logic [W-1:0]  det,
  input logic [W-1:0]  dir_q,
  input logic [W-1:0]  sout_q,
  input logic [W-1:0]  bfout_q,
  input logic          fault_s,
  input logic          sleep_mode
);
  // R2 R3
  dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr[AW-1:2] == (AW-2)'(OFS_DIR)) |=> (pin_oe == $past(bus_wdata)));

  // R5 R6
  stat_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat & ~$past(stat) & ~$past(det)) == '0));

  // R8
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (stat != '0));

  // R11
  fault_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_s |-> (pin_out == (bfout_q & dir_q)));

  // R10
  sleep_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_mode && !fault_s) |-> (pin_out == (sout_q & dir_q)));
endmodule

bind pio_bank16 pio_bank16_chk #(.W(PINS), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .pin_oe(pin_oe), .pin_out(pin_out), .irq(irq),
  .stat(stat_w), .det(det_w), .dir_q(dir_q), .sout_q(sout_q),
  .bfout_q(bfout_q), .fault_s(fault_s), .sleep_mode(sleep_mode)
);

// File: tb/sim_pio_bank16.sv
`timescale 1ns/1ps
module sim_pio_bank16;
  localparam logic [5:0] A_MASK = 6'h00, A_DIR = 6'h04, A_OUT = 6'h08,
    A_TRIG = 6'h0C, A_EDGE = 6'h10, A_LVL = 6'h14, A_SMASK = 6'h18,
    A_SOUT = 6'h1C, A_BFOUT = 6'h20, A_STAT = 6'h24, A_ALT = 6'h28,
    A_SCONF = 6'h2C, A_PINS = 6'h30, A_HOLE = 6'h34;
  localparam int SEL_RD = 0, SEL_OUT = 1, SEL_OE = 2, SEL_IRQ = 3, SEL_ALT = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic [5:0] bus_addr;
  logic bus_we;
  logic [15:0] bus_wdata, bus_rdata, pin_in, pin_out, pin_oe, alt_sel;
  logic sleep_req, batt_fault, irq;

  typedef struct {
    int          sel;
    logic [15:0] exp;
    string       req;
  } item_t;
  item_t exp_q[$];
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pio_bank16 u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .alt_sel(alt_sel),
    .sleep_req(sleep_req), .batt_fault(batt_fault), .irq(irq)
  );

  // Monitor: pops expected items and compares at the falling edge.
  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      item_t it;
      logic [15:0] act;
      it = exp_q.pop_front();
      case (it.sel)
        SEL_RD:  act = bus_rdata;
        SEL_OUT: act = pin_out;
        SEL_OE:  act = pin_oe;
        SEL_IRQ: act = {15'd0, irq};
        default: act = alt_sel;
      endcase
      total++;
      if (act !== it.exp) begin
        bad++;
        $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.exp);
      end
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    step(1);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    step(1);
    bus_we = 1'b0;
  endtask

  task automatic expect_sig(input int sel, input logic [15:0] e, input string req);
    item_t it;
    step(1);
    it.sel = sel; it.exp = e; it.req = req;
    exp_q.push_back(it);
  endtask

  task automatic expect_rd(input logic [5:0] a, input logic [15:0] e, input string req);
    item_t it;
    step(1);
    bus_addr = a;
    it.sel = SEL_RD; it.exp = e; it.req = req;
    exp_q.push_back(it);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
    pin_in = 16'hFFFF; sleep_req = 1'b0; batt_fault = 1'b0;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    expect_sig(SEL_OE, 16'h0000, "R1");
    expect_sig(SEL_IRQ, 16'h0000, "R1");
    expect_rd(A_MASK, 16'hFFFF, "R1");
    expect_rd(A_DIR, 16'h0000, "R1");
    step(4);
    wr(A_STAT, 16'hFFFF);
    expect_rd(A_STAT, 16'h0000, "R6");

    // R2 R3 direction and output
    wr(A_DIR, 16'h0F0F);
    wr(A_OUT, 16'h00FF);
    expect_rd(A_DIR, 16'h0F0F, "R2");
    expect_rd(A_OUT, 16'h00FF, "R2");
    expect_sig(SEL_OE, 16'h0F0F, "R3");
    expect_sig(SEL_OUT, 16'h000F, "R3");

    // R4 synchronised pin status, R5 low-level detection
    pin_in = 16'hFFF5;
    step(3);
    expect_rd(A_PINS, 16'hFFF5, "R4");
    expect_rd(A_STAT, 16'h000A, "R5");
    pin_in = 16'hFFFF;
    step(3);
    wr(A_STAT, 16'hFFFF);
    expect_rd(A_STAT, 16'h0000, "R6");

    // R5 rising-edge selection ignores falling edge
    wr(A_TRIG, 16'h0001);
    wr(A_EDGE, 16'h0001);
    pin_in = 16'hFFFE;
    step(4);
    expect_rd(A_STAT, 16'h0000, "R5");
    pin_in = 16'hFFFF;
    step(4);
    expect_rd(A_STAT, 16'h0001, "R5");

    // R6 held high level survives write-one clear
    wr(A_LVL, 16'h0002);
    step(2);
    wr(A_STAT, 16'hFFFF);
    expect_rd(A_STAT, 16'h0002, "R6");
    wr(A_LVL, 16'h0000);
    step(3);
    wr(A_STAT, 16'h0000);
    expect_rd(A_STAT, 16'h0002, "R6");
    wr(A_STAT, 16'hFFFF);
    expect_rd(A_STAT, 16'h0000, "R6");

    // R8 mask gating
    pin_in = 16'hFFFE; step(4);
    pin_in = 16'hFFFF; step(4);
    expect_rd(A_STAT, 16'h0001, "R5");
    expect_sig(SEL_IRQ, 16'h0000, "R8");
    wr(A_MASK, 16'hFFFE);
    expect_sig(SEL_IRQ, 16'h0001, "R8");

    // R9 R10 sleep mask and sleep levels
    wr(A_SOUT, 16'h0303);
    wr(A_SMASK, 16'h0001);
    sleep_req = 1'b1; step(5);
    expect_sig(SEL_IRQ, 16'h0000, "R9");
    expect_sig(SEL_OUT, 16'h0303, "R10");
    sleep_req = 1'b0; step(5);
    expect_sig(SEL_IRQ, 16'h0001, "R9");
    expect_sig(SEL_OUT, 16'h000F, "R12");

    // R11 fault level wins over sleep
    wr(A_BFOUT, 16'h0A0A);
    sleep_req = 1'b1; batt_fault = 1'b1; step(5);
    expect_sig(SEL_OUT, 16'h0A0A, "R11");
    batt_fault = 1'b0; step(5);
    expect_sig(SEL_OUT, 16'h0303, "R11");
    sleep_req = 1'b0; step(5);
    expect_sig(SEL_OUT, 16'h000F, "R11");

    // R12 autosleep holds sleep levels until an interrupt wakes
    wr(A_MASK, 16'hFFFF);
    wr(A_STAT, 16'hFFFF);
    wr(A_SCONF, 16'h0002);
    expect_rd(A_SCONF, 16'h0002, "R2");
    sleep_req = 1'b1; step(4);
    sleep_req = 1'b0; step(6);
    expect_sig(SEL_OUT, 16'h0303, "R12");
    wr(A_TRIG, 16'h0101);
    wr(A_EDGE, 16'h0101);
    wr(A_MASK, 16'hFEFF);
    pin_in = 16'hFEFF; step(4);
    expect_sig(SEL_OUT, 16'h0303, "R12");
    pin_in = 16'hFFFF; step(4);
    step(3);
    expect_sig(SEL_IRQ, 16'h0001, "R12");
    expect_sig(SEL_OUT, 16'h000F, "R12");

    // R7 alternate-function flags
    wr(A_ALT, 16'h8001);
    expect_rd(A_ALT, 16'h8001, "R7");
    expect_sig(SEL_ALT, 16'h8001, "R7");

    // R13 unmapped read and ignored writes
    expect_rd(A_HOLE, 16'h0000, "R13");
    wr(A_PINS, 16'h1234);
    expect_rd(A_PINS, 16'hFFFF, "R13");
    wr(A_HOLE, 16'h5555);
    expect_rd(A_HOLE, 16'h0000, "R13");
    expect_rd(A_DIR, 16'h0F0F, "R13");

    step(2);
    @(negedge clk);
    #1;
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule